// File: doc/BRIEF.md
# Trigger-Selectable Interrupt Request Capture

This block is the front end of an interrupt controller. It watches eight request lines on the clock and keeps one pending bit per line. A trigger-mode register gives each line one of two modes. In edge mode, a rising line latches a request, and the request stays latched until the controller core acknowledges it. In level mode, the pending bit simply tracks the line. An acknowledge has no effect on a level-mode line.

The trigger-mode register can be written by software. Only the bit positions allowed by a fixed per-instance mask can be set, so the same design serves both a primary instance (mask 0xF8) and a secondary instance (mask 0xDE). The controller core can issue an initialization pulse. This pulse clears every pending bit and every stored previous level, but the trigger-mode register keeps its value. Priority resolution, masking and vector generation live in the controller core that consumes the pending vector.

Top module: `trig_req_capture`

## Requirements
- R1: After a synchronous reset, the pending vector and the trigger-mode register are all zero.
- R2: When trigger-mode bit n is 1 (level mode), pending bit n on the clock edge after a sample equals the sampled line n.
- R3: When trigger-mode bit n is 0 (edge mode), a sample where line n is high and its stored previous level is low sets pending bit n one clock edge later.
- R4: In edge mode, a falling line or a line held high leaves pending bit n unchanged; no second request is latched without a new rising sample.
- R5: In edge mode, acknowledge bit n clears pending bit n one clock edge later when no new rising sample occurs in the same cycle.
- R6: In edge mode, an acknowledge and a new rising sample of the same line in one cycle leave pending bit n set.
- R7: A write stores the written byte ANDed with the parameter WR_MASK into the trigger-mode register, visible one edge later. The default mask is 0xF8, the secondary instance uses 0xDE, and bits outside the mask stay 0.
- R8: An initialization pulse clears all pending bits and stored previous levels and keeps the trigger-mode register. A line that is high after the pulse counts as a new rising sample.
- R9: In level mode, acknowledge has no effect on pending bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Controller initialization pulse; clears capture state only |
| line_i | input | NUM_LINES | Request lines, sampled every clock |
| ack_i | input | NUM_LINES | Per-line acknowledge from the controller core |
| mode_wr_i | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata_i | input | NUM_LINES | Write data (1 = level, 0 = edge) |
| mode_o | output | NUM_LINES | Trigger-mode register contents (read-back) |
| pend_o | output | NUM_LINES | Registered pending-request vector |

## Verification
The bench builds two instances from the same stimulus: one with the default mask 0xF8, and one with WR_MASK set to 0xDE. With the default mask, lines 0 to 2 are fixed in edge mode, while line 3 and above can be switched between modes mid-run. The 0xDE instance brings within reach a level-mode line below position 3 (line 1) and mask holes at bits 0 and 5. Writing all ones to both instances exposes the difference between the two masks at the read-back.

// File: rtl/trig_req_pkg.sv
package trig_req_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // Next pending value for one edge-mode line.
  function automatic logic edge_next(input logic line, input logic prev,
                                     input logic pend, input logic ack);
    return (line & ~prev) | (pend & ~ack);
  endfunction
endpackage

// File: rtl/trig_mode_reg.sv
module trig_mode_reg #(
  parameter int                   NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK   = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)       mode_q <= '0;
    else if (wr_i) mode_q <= wdata_i & WR_MASK;
  end

  assign mode_o = mode_q;

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (mode_q == ($past(wdata_i) & WR_MASK)));  // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(mode_q));  // R8
endmodule

// File: rtl/req_line_cell.sv
module req_line_cell
  import trig_req_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic line_i,
  input  logic mode_i,
  input  logic ack_i,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;
  trig_mode_e mode;

  assign mode = trig_mode_e'(mode_i);

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      if (mode == TRIG_LEVEL) pend_q <= line_i;
      else                    pend_q <= edge_next(line_i, prev_q, pend_q, ack_i);
    end
  end

  assign pend_o = pend_q;

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    (!init_i && mode_i) |=> (pend_q == $past(line_i)));  // R2
  AST_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !mode_i && line_i && !prev_q) |=> pend_q);  // R6
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !mode_i && pend_q && !ack_i) |=> pend_q);  // R4
  AST_EDGE_ACK: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !mode_i && ack_i && !(line_i && !prev_q)) |=> !pend_q);  // R5
  AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (!pend_q && !prev_q));  // R8
endmodule

// File: rtl/trig_req_capture.sv
module trig_req_capture #(
  parameter int                   NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK   = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init_i,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] ack_i,
  input  logic                 mode_wr_i,
  input  logic [NUM_LINES-1:0] mode_wdata_i,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] mode_w;

  trig_mode_reg #(.NUM_LINES(NUM_LINES), .WR_MASK(WR_MASK)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (mode_wr_i),
    .wdata_i (mode_wdata_i),
    .mode_o  (mode_w)
  );

  assign mode_o = mode_w;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    req_line_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .init_i (init_i),
      .line_i (line_i[g]),
      .mode_i (mode_w[g]),
      .ack_i  (ack_i[g]),
      .pend_o (pend_o[g])
    );
  end

  AST_LOCKED_BITS: assert property (@(posedge clk) disable iff (rst)
    mode_wr_i |=> ((mode_o & ~WR_MASK) == '0));  // R7
  AST_LEVEL_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!init_i && ((mode_o & ack_i) != '0)) |=>
      (((pend_o ^ $past(line_i)) & $past(mode_o)) == '0));  // R9
endmodule

// File: tb/test_trig_req_capture.sv
module test_trig_req_capture;
  localparam int N = 8;
  localparam int ROWS = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init = 1'b0;
  logic [N-1:0] line = '0, ack = '0, wdata = '0;
  logic wr = 1'b0;
  logic [N-1:0] mode_p, pend_p, mode_s, pend_s;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_req_capture #(.NUM_LINES(N), .WR_MASK(8'hF8)) i_trig_req_capture (
    .clk(clk), .rst(rst), .init_i(init), .line_i(line), .ack_i(ack),
    .mode_wr_i(wr), .mode_wdata_i(wdata), .mode_o(mode_p), .pend_o(pend_p));

  trig_req_capture #(.NUM_LINES(N), .WR_MASK(8'hDE)) i_trig_req_capture_sec (
    .clk(clk), .rst(rst), .init_i(init), .line_i(line), .ack_i(ack),
    .mode_wr_i(wr), .mode_wdata_i(wdata), .mode_o(mode_s), .pend_o(pend_s));

  // Row fields: {wr, init, wdata, line, ack, exp_pend, exp_mode} for the 0xF8 instance
  localparam logic [41:0] TBL [0:ROWS-1] = '{
    {1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hF8},  // R7 mask on write
    {1'b0, 1'b0, 8'h00, 8'h09, 8'h00, 8'h09, 8'hF8},  // R3 edge line0, R2 level line3
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 8'hF8},  // R4 falling keeps, R2 level drops
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h09, 8'h00, 8'hF8},  // R5 ack clears edge
    {1'b0, 1'b0, 8'h00, 8'h08, 8'h08, 8'h08, 8'hF8},  // R9 ack ignored in level
    {1'b1, 1'b0, 8'h00, 8'h08, 8'h00, 8'h08, 8'h00},  // R7 switch to edge
    {1'b0, 1'b0, 8'h00, 8'h08, 8'h00, 8'h08, 8'h00},  // R4 held high, pend held
    {1'b0, 1'b0, 8'h00, 8'h08, 8'h08, 8'h00, 8'h00},  // R5 ack clears
    {1'b0, 1'b0, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00},  // R4 no retrigger
    {1'b0, 1'b0, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00},  // R6 rise with ack
    {1'b0, 1'b0, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00},  // R5 ack, no new rise
    {1'b1, 1'b0, 8'h5A, 8'h81, 8'h00, 8'h80, 8'h58},  // R7 partial write, R3 line7
    {1'b0, 1'b1, 8'h00, 8'h81, 8'h00, 8'h00, 8'h58},  // R8 init clears, mode kept
    {1'b0, 1'b0, 8'h00, 8'h81, 8'h00, 8'h81, 8'h58}   // R8 high line re-latches
  };
  localparam string ROW_REQ [0:ROWS-1] = '{
    "R7", "R3 R2", "R4 R2", "R5", "R9", "R7", "R4", "R5", "R4", "R6", "R5",
    "R7 R3", "R8", "R8"};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1", pend_p, 8'h00, "pend after reset");
    check("R1", mode_p, 8'h00, "mode after reset");
    check("R1", mode_s, 8'h00, "secondary mode after reset");

    for (int r = 0; r < ROWS; r++) begin
      {wr, init, wdata, line, ack} = TBL[r][41:16];
      tick();
      check(ROW_REQ[r], pend_p, TBL[r][15:8], $sformatf("row %0d pend", r));
      check(ROW_REQ[r], mode_p, TBL[r][7:0], $sformatf("row %0d mode", r));
    end

    // R7 both masks from one all-ones write
    {wr, init, wdata, line, ack} = {1'b1, 1'b0, 8'hFF, 8'h00, 8'h00};
    tick();
    check("R7", mode_p, 8'hF8, "primary mask");
    check("R7", mode_s, 8'hDE, "secondary mask");

    // R2/R9 secondary line1 is level; R6 primary line1 edge rise with ack
    {wr, init, wdata, line, ack} = {1'b0, 1'b0, 8'h00, 8'h02, 8'h02};
    tick();
    check("R9", pend_s & 8'h02, 8'h02, "secondary level line1 with ack");
    check("R6", pend_p & 8'h02, 8'h02, "primary edge line1 rise with ack");

    // R1 reset mid-run
    line = 8'h00; ack = 8'h00;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1", pend_p | pend_s, 8'h00, "pend after late reset");
    check("R1", mode_p | mode_s, 8'h00, "mode after late reset");

    finish_run();
  end
endmodule